// File: doc/BRIEF.md
# Opcode and Pattern Data Descrambler

This block sits on the read data returned from external memory and restores two scrambled byte streams before their consumers see them. Bytes fetched by the CPU as instruction opcodes can be XOR-scrambled with a fixed key. Bytes fetched by the picture path as tile pattern data can be scrambled by a fixed pairwise exchange of bit positions. Operand and ordinary data reads always pass through untouched. Both descramble paths are purely combinational, so corrected data is valid in the same bus cycle it is read.

Software controls both modes through one write-only byte register on the CPU write bus. A change to the pattern mode takes effect on the next cycle. A change to the opcode mode is only armed by the write. It is committed when the CPU reaches the instruction that follows the next jump. This lets code running from unscrambled memory jump into scrambled memory, and the reverse, without breaking the fetch stream. Jumps are detected from the descrambled opcode value. An opcode fetch is marked by a sync strobe that comes with the read.

Top module: `fetch_descrambler`

## Requirements
- R1: After reset, opcode scrambling is inactive, pattern scrambling is inactive and no opcode change is armed, so both read paths return their raw bytes.
- R2: A control write whose bits [7:6] are 11 turns pattern descrambling on from the next cycle, and 00 turns it off. While it is on, output bits 0/4, 1/2, 3/7 and 5/6 are the raw byte with each of these pairs exchanged.
- R3: A control write whose bits [7:6] are 01 or 10 leaves the pattern mode unchanged.
- R4: A control write whose bits {2,0} are 11 (for example 0x05) arms opcode descrambling on, and 00 (for example 0x00) arms it off. Opcode fetches keep using the old mode until the commit point.
- R5: A jump is an opcode fetch whose descrambled value is 0x4C or 0x6C. The armed mode is committed at the first opcode fetch that follows the two operand reads of that jump, and that fetch already uses the new mode.
- R6: While opcode descrambling is active, a read with sync high returns raw XOR 0xA1. A read with sync low returns the raw byte.
- R7: A second arming write that comes before the commit replaces the armed value.
- R8: A control write whose bits {2,0} are 01 or 10 arms nothing and leaves any earlier armed value in place.
- R9: Writes to any address other than the control address (default 0x411E) have no effect on either mode.
- R10: Opcode fetches other than a jump, and jumps while nothing is armed, do not change the opcode mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | ADDR_W | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_rd_en | input | 1 | CPU read strobe for this cycle |
| cpu_sync | input | 1 | Marks the current read as an opcode fetch |
| cpu_rdata_raw | input | 8 | Byte from memory on the CPU read path |
| cpu_rdata | output | 8 | Descrambled byte to the CPU |
| pat_raw | input | 8 | Pattern byte from memory |
| pat_data | output | 8 | Descrambled pattern byte |

## Verification
The bench builds the block with its default parameters: a 16-bit write address, the control register at 0x411E, and two operand reads per jump. With these values the neighbouring address 0x411F tests address decode exactly, and both jump forms can be walked through their full operand count. The bench also checks an indirect jump whose pointer reads are followed by extra data reads that must not commit early. Random traffic mixes arming writes, jumps of both kinds and plain reads, and a bench model predicts every output byte.

// File: rtl/desc_pkg.sv
package desc_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] OPC_JMP_ABS = 8'h4C;
    localparam logic [BYTE_W-1:0] OPC_JMP_IND = 8'h6C;

    // control byte field positions
    localparam int OPF_LO  = 0;
    localparam int OPF_HI  = 2;
    localparam int PATF_LO = 6;
    localparam int PATF_HI = 7;

    typedef struct packed {
        logic op_active;
        logic pend_valid;
        logic pend_val;
        logic pat_on;
    } ctrl_state_t;

    function automatic bit is_jump(input logic [BYTE_W-1:0] opc);
        return (opc == OPC_JMP_ABS) || (opc == OPC_JMP_IND);
    endfunction

    // pattern bit that lands in position b
    function automatic int swap_partner(input int b);
        case (b)
            0: return 4;
            4: return 0;
            1: return 2;
            2: return 1;
            3: return 7;
            7: return 3;
            5: return 6;
            default: return 5;
        endcase
    endfunction
endpackage

// File: rtl/desc_ctrl_dec.sv
module desc_ctrl_dec
    import desc_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h411E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              commit,
    output logic              op_active,
    output logic              pend_valid,
    output logic              pend_val,
    output logic              pat_on
);
    ctrl_state_t state_d, state_q;
    logic        hit;
    logic [1:0]  op_fld, pat_fld;
    logic        unused_bits;

    assign hit         = wr_en && (wr_addr == CTRL_ADDR);
    assign op_fld      = {wr_data[OPF_HI], wr_data[OPF_LO]};
    assign pat_fld     = {wr_data[PATF_HI], wr_data[PATF_LO]};
    assign unused_bits = ^{wr_data[5:3], wr_data[1]};

    always_comb begin
        state_d = state_q;
        if (commit) begin
            state_d.op_active  = state_q.pend_val;
            state_d.pend_valid = 1'b0;
        end
        if (hit) begin
            case (op_fld)
                2'b00: begin state_d.pend_valid = 1'b1; state_d.pend_val = 1'b0; end
                2'b11: begin state_d.pend_valid = 1'b1; state_d.pend_val = 1'b1; end
                default: ;
            endcase
            case (pat_fld)
                2'b00: state_d.pat_on = 1'b0;
                2'b11: state_d.pat_on = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign op_active  = state_q.op_active;
    assign pend_valid = state_q.pend_valid;
    assign pend_val   = state_q.pend_val;
    assign pat_on     = state_q.pat_on;
endmodule

// File: rtl/desc_jmp_track.sv
module desc_jmp_track
    import desc_pkg::*;
#(
    parameter int OPERAND_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              sync,
    input  logic [BYTE_W-1:0] opcode,
    input  logic              pend_valid,
    output logic              commit
);
    localparam int CW = $clog2(OPERAND_BYTES + 1);
    localparam logic [CW-1:0] OPS_INIT = CW'(OPERAND_BYTES);

    typedef struct packed {
        logic          jmp_seen;
        logic [CW-1:0] ops_left;
    } trk_state_t;

    trk_state_t state_d, state_q;

    // commit depends only on state and strobes, never on the data byte
    assign commit = rd_en && sync && pend_valid && state_q.jmp_seen
                    && (state_q.ops_left == '0);

    always_comb begin
        state_d = state_q;
        if (rd_en) begin
            if (sync) begin
                state_d.jmp_seen = is_jump(opcode);
                state_d.ops_left = is_jump(opcode) ? OPS_INIT : '0;
            end else if (state_q.ops_left != '0) begin
                state_d.ops_left = state_q.ops_left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/desc_opcode_path.sv
module desc_opcode_path
    import desc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] KEY = 8'hA1
) (
    input  logic              rd_en,
    input  logic              sync,
    input  logic              scramble_now,
    input  logic [BYTE_W-1:0] raw,
    output logic [BYTE_W-1:0] data
);
    always_comb begin
        data = raw;
        if (rd_en && sync && scramble_now) data = raw ^ KEY;
    end
endmodule

// File: rtl/desc_pattern_path.sv
module desc_pattern_path
    import desc_pkg::*;
(
    input  logic              enable,
    input  logic [BYTE_W-1:0] raw,
    output logic [BYTE_W-1:0] data
);
    logic [BYTE_W-1:0] swapped;

    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        assign swapped[b] = raw[swap_partner(b)];
    end

    assign data = enable ? swapped : raw;
endmodule

// File: rtl/fetch_descrambler.sv
module fetch_descrambler
    import desc_pkg::*;
#(
    parameter int                ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR     = 16'h411E,
    parameter int                OPERAND_BYTES = 2,
    parameter logic [7:0]        OPC_KEY       = 8'hA1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              cpu_rd_en,
    input  logic              cpu_sync,
    input  logic [7:0]        cpu_rdata_raw,
    output logic [7:0]        cpu_rdata,
    input  logic [7:0]        pat_raw,
    output logic [7:0]        pat_data
);
    logic commit_w, op_active_w, pend_valid_w, pend_val_w, pat_on_w;
    logic scramble_now_w;

    desc_ctrl_dec #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit(commit_w), .op_active(op_active_w),
        .pend_valid(pend_valid_w), .pend_val(pend_val_w), .pat_on(pat_on_w)
    );

    desc_jmp_track #(.OPERAND_BYTES(OPERAND_BYTES)) trk_i (
        .clk(clk), .rst_n(rst_n), .rd_en(cpu_rd_en), .sync(cpu_sync),
        .opcode(cpu_rdata), .pend_valid(pend_valid_w), .commit(commit_w)
    );

    // the committing fetch already sees the armed mode
    assign scramble_now_w = commit_w ? pend_val_w : op_active_w;

    desc_opcode_path #(.KEY(OPC_KEY)) opc_i (
        .rd_en(cpu_rd_en), .sync(cpu_sync), .scramble_now(scramble_now_w),
        .raw(cpu_rdata_raw), .data(cpu_rdata)
    );

    desc_pattern_path pat_i (
        .enable(pat_on_w), .raw(pat_raw), .data(pat_data)
    );
endmodule

// File: rtl/desc_checker.sv
module desc_checker #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h411E
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              cpu_rd_en,
    input logic              cpu_sync,
    input logic [7:0]        cpu_rdata_raw,
    input logic [7:0]        cpu_rdata,
    input logic [7:0]        pat_raw,
    input logic [7:0]        pat_data,
    input logic              commit,
    input logic              op_active,
    input logic              pend_valid,
    input logic              pat_on
);
    logic ctrl_hit;
    assign ctrl_hit = wr_en && (wr_addr == CTRL_ADDR);

    // R2: an on-request makes the pattern path exchange bit pairs next cycle
    a_r2_pattern_on: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && wr_data[7:6] == 2'b11) |=>
        (pat_data == {pat_raw[3], pat_raw[5], pat_raw[6], pat_raw[0],
                      pat_raw[7], pat_raw[1], pat_raw[2], pat_raw[4]}));

    // R3: mixed pattern field keeps the pattern mode
    a_r3_pattern_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && (wr_data[7] != wr_data[6])) |=> $stable(pat_on));

    // R4, R10: the opcode mode moves only at a commit
    a_r4_active_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(op_active));

    // R5: a commit happens only on an opcode fetch with something armed
    a_r5_commit_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (cpu_rd_en && cpu_sync && pend_valid));

    // R5: the armed value is consumed by the commit
    a_r5_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !ctrl_hit) |=> !pend_valid);

    // R6: operand and data reads are never altered
    a_r6_operand_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_en && !cpu_sync) |-> (cpu_rdata == cpu_rdata_raw));

    // R9: foreign addresses leave the pattern mode alone
    a_r9_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != CTRL_ADDR) |=> $stable(pat_on));
endmodule

bind fetch_descrambler desc_checker #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_rd_en(cpu_rd_en), .cpu_sync(cpu_sync), .cpu_rdata_raw(cpu_rdata_raw),
    .cpu_rdata(cpu_rdata), .pat_raw(pat_raw), .pat_data(pat_data),
    .commit(commit_w), .op_active(op_active_w), .pend_valid(pend_valid_w),
    .pat_on(pat_on_w)
);

// File: tb/fetch_descrambler_tb_top.sv
`timescale 1ns/1ps
module fetch_descrambler_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cpu_rd_en = 1'b0;
    logic        cpu_sync = 1'b0;
    logic [7:0]  cpu_rdata_raw = '0;
    logic [7:0]  cpu_rdata;
    logic [7:0]  pat_raw = '0;
    logic [7:0]  pat_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model state
    bit       m_act, m_pv, m_pval, m_pat, m_jmp;
    int       m_ops;

    always #2.5 clk = ~clk;

    fetch_descrambler dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cpu_rd_en(cpu_rd_en), .cpu_sync(cpu_sync), .cpu_rdata_raw(cpu_rdata_raw),
        .cpu_rdata(cpu_rdata), .pat_raw(pat_raw), .pat_data(pat_data)
    );

    function automatic logic [7:0] ref_swap(input logic [7:0] v);
        logic [7:0] o;
        o[4] = v[0]; o[0] = v[4];
        o[2] = v[1]; o[1] = v[2];
        o[7] = v[3]; o[3] = v[7];
        o[6] = v[5]; o[5] = v[6];
        return o;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    task automatic bus(input string tag, input bit rd, input bit sy, input logic [7:0] raw,
                       input bit wr, input logic [15:0] addr, input logic [7:0] wd,
                       input logic [7:0] praw);
        bit commit, eff;
        logic [7:0] exp_c;
        @(negedge clk);
        cpu_rd_en = rd; cpu_sync = sy; cpu_rdata_raw = raw;
        wr_en = wr; wr_addr = addr; wr_data = wd; pat_raw = praw;
        #1;
        commit = rd && sy && m_pv && m_jmp && (m_ops == 0);
        eff    = commit ? m_pval : m_act;
        exp_c  = (rd && sy && eff) ? (raw ^ 8'hA1) : raw;
        check(tag, "cpu", cpu_rdata, exp_c);
        check(tag, "pattern", pat_data, m_pat ? ref_swap(praw) : praw);
        if (commit) begin m_act = m_pval; m_pv = 0; end
        if (rd) begin
            if (sy) begin
                m_jmp = (exp_c == 8'h4C) || (exp_c == 8'h6C);
                m_ops = m_jmp ? 2 : 0;
            end else if (m_ops > 0) m_ops--;
        end
        if (wr && addr == 16'h411E) begin
            if (wd[2] == wd[0]) begin m_pv = 1; m_pval = wd[0]; end
            if (wd[7] == wd[6]) m_pat = wd[7];
        end
    endtask

    task automatic opf(input string tag, input logic [7:0] raw);
        bus(tag, 1, 1, raw, 0, 16'h0, 8'h0, raw + 8'h11);
    endtask
    task automatic opr(input string tag, input logic [7:0] raw);
        bus(tag, 1, 0, raw, 0, 16'h0, 8'h0, raw ^ 8'h5A);
    endtask
    task automatic wreg(input string tag, input logic [15:0] addr, input logic [7:0] v);
        bus(tag, 0, 0, 8'h00, 1, addr, v, 8'h01);
    endtask

    initial begin
        #(5.0 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        if (!done) $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state passes both paths through
        opf("R1", 8'h33);
        opr("R1", 8'h81);
        bus("R1", 0, 0, 8'h00, 0, 16'h0, 8'h00, 8'h12);
        // R9: neighbour address is ignored
        wreg("R9", 16'h411F, 8'hC5);
        bus("R9", 0, 0, 8'h00, 0, 16'h0, 8'h00, 8'h0F);
        opf("R9", 8'h4C); opr("R9", 8'h00); opr("R9", 8'h80); opf("R9", 8'hEA);
        // R2: pattern on then visible next cycle
        wreg("R2", 16'h411E, 8'hC0);
        bus("R2", 0, 0, 8'h00, 0, 16'h0, 8'h00, 8'h01);
        bus("R2", 0, 0, 8'h00, 0, 16'h0, 8'h00, 8'h2A);
        // R3: mixed pattern field holds
        wreg("R3", 16'h411E, 8'h40);
        bus("R3", 0, 0, 8'h00, 0, 16'h0, 8'h00, 8'h08);
        wreg("R3", 16'h411E, 8'h84);
        bus("R3", 0, 0, 8'h00, 0, 16'h0, 8'h00, 8'h60);
        // R4: arming does not act at once
        wreg("R4", 16'h411E, 8'hC5);
        opf("R4", 8'hEA); opr("R4", 8'h12); opf("R4", 8'hA9);
        // R5: absolute jump, commit on following fetch
        opf("R5", 8'h4C); opr("R5", 8'h00); opr("R5", 8'h90); opf("R5", 8'h33);
        // R6: operands and data untouched while active
        opf("R6", 8'hED); opr("R6", 8'h77); opr("R6", 8'hFF); opf("R6", 8'h00);
        // R10: non-jump fetches keep mode; R8: mixed op field arms nothing
        wreg("R8", 16'h411E, 8'hC1);
        opf("R8", 8'hCD); opr("R8", 8'h10); opr("R8", 8'h20); opf("R10", 8'h33);
        opf("R10", 8'h0B); opf("R10", 8'h60);
        // R7: later arm replaces earlier; indirect jump with pointer reads
        wreg("R7", 16'h411E, 8'h00);
        wreg("R7", 16'h411E, 8'hC5);
        wreg("R7", 16'h411E, 8'hC0);
        opf("R7", 8'hCD); opr("R7", 8'h00); opr("R7", 8'h30);
        opr("R7", 8'h44); opr("R7", 8'h55); opf("R7", 8'h33);
        opf("R7", 8'h33); opr("R7", 8'h01);
        // R4: arm on again, jump with mixed write in between keeps it (R8)
        wreg("R4", 16'h411E, 8'h05);
        wreg("R8", 16'h411E, 8'h04);
        opf("R8", 8'h4C); opr("R8", 8'h01); opr("R8", 8'h02); opf("R8", 8'h4C ^ 8'hA1);
        opr("R5", 8'h03); opr("R5", 8'h04); opf("R5", 8'h12);
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            int k;
            logic [7:0] v;
            k = $urandom_range(0, 9);
            v = 8'($urandom);
            case (k)
                0: begin
                    case ($urandom_range(0, 4))
                        0: v = 8'h00; 1: v = 8'h05; 2: v = 8'hC0; 3: v = 8'hC5; default: ;
                    endcase
                    wreg("R7", ($urandom_range(0, 3) == 0) ? 16'h411F : 16'h411E, v);
                end
                1, 2: opf("R5", m_act ? (8'h4C ^ 8'hA1) : 8'h4C);
                3: opf("R5", m_act ? (8'h6C ^ 8'hA1) : 8'h6C);
                4, 5: opf("R10", v);
                default: bus("R6", 1, 0, v, 0, 16'h0, 8'h0, 8'($urandom));
            endcase
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule